// File: doc/BRIEF.md
# Load/Store Effective Address and Byte-Lane Steering Unit

This unit sits between the register file and a 32-bit, byte-addressed data memory port. For each accepted request it forms the effective address from a base value and an offset. The offset is either an unsigned immediate or a second register shifted left by a small constant. It is added or subtracted, and the unit decides whether the base register must be updated. Three addressing forms are covered: offset-only, offset with base update, and base-first with base update afterwards.

The unit also maps bytes onto the four lanes of the memory word. Stores of a byte, halfword or word are replicated across the lanes and tagged with byte enables. Loads pick the addressed bytes out of the returned word and zero-extend them. The lane order follows a byte-order mode that is sampled while reset is high and then held. Accesses whose address is not a multiple of their size are not split. They raise a fault flag, write no lanes and update no register.

Each request is registered once, so every memory-side and writeback output belongs to the request accepted on the previous clock edge. Load data is formed combinationally from `mem_rdata_i` while that access is presented.

Top module: `lsu_addr_lane`

## Requirements
- R1: While reset is high and in the first cycle after it, `mem_valid_o`, `mem_write_o`, `mem_be_o`, `mem_wdata_o`, `ld_data_o`, `wb_en_o` and `misalign_o` are all zero.
- R2: The offset is `imm_i` zero-extended when `req_use_reg_i`=0, or `roff_i << shamt_i` when it is 1. The offset is subtracted from `base_i` when `req_sub_i`=1 and added otherwise, modulo 2^32.
- R3: With `req_pre_i`=1 and `req_wb_i`=0, the memory address is base±offset and `wb_en_o` stays low.
- R4: With `req_pre_i`=1 and `req_wb_i`=1, the memory address is base±offset, `wb_en_o` is high and `wb_value_o` equals that address.
- R5: With `req_pre_i`=0, the memory address is `base_i` unchanged, `wb_en_o` is high and `wb_value_o` is base±offset, whatever `req_wb_i` is.
- R6: A request accepted at a clock edge appears on the outputs for exactly the following cycle, with `mem_valid_o` high. `mem_write_o` is high only when `req_load_i` was 0. With no request, `mem_valid_o` is low in the next cycle.
- R7: The size code `req_size_i` is 0 for byte, 1 for halfword, and 2 or 3 for word. In little-endian mode, lane k (bits 8k+7:8k) holds the byte at address offset k. In big-endian mode, lane k holds offset 3-k. A byte access enables one lane and a halfword access enables two lanes. A word access enables all four lanes, and a word's bits pass through unchanged in both modes.
- R8: A store drives `mem_wdata_o` with the low byte copied into all four lanes, the low halfword copied into both halves, or the whole word, according to size. A store drives no other data pattern.
- R9: A load returns the addressed byte or halfword zero-extended, or the whole word, in `ld_data_o`. In little-endian mode the lower address is the less significant byte; in big-endian mode it is the more significant byte. `ld_data_o` is zero for stores and for idle cycles.
- R10: A halfword at an odd address, or a word whose two low address bits are not both zero, sets `misalign_o`. In that case `mem_be_o` is zero, `wb_en_o` is low and `ld_data_o` is zero.
- R11: `cfg_big_endian_i` (1 = big-endian) is sampled only while reset is high. Changes to it after reset do not affect lane steering.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| cfg_big_endian_i | input | 1 | Byte-order mode, sampled during reset (1 = big-endian) |
| req_valid_i | input | 1 | Request present this cycle |
| req_load_i | input | 1 | 1 = load, 0 = store |
| req_size_i | input | 2 | 0 byte, 1 halfword, 2/3 word |
| req_pre_i | input | 1 | 1 = apply offset before access, 0 = after |
| req_wb_i | input | 1 | Update base when offset is applied before access |
| req_sub_i | input | 1 | 1 = subtract offset |
| req_use_reg_i | input | 1 | 1 = register offset, 0 = immediate |
| base_i | input | 32 | Base register value |
| imm_i | input | IMM_W | Unsigned immediate offset |
| roff_i | input | 32 | Register offset value |
| shamt_i | input | SHAMT_W | Left shift applied to register offset |
| st_data_i | input | 32 | Store source register value |
| mem_rdata_i | input | 32 | Word returned by memory for the presented address |
| mem_valid_o | output | 1 | Access presented this cycle |
| mem_write_o | output | 1 | Presented access is a store |
| mem_addr_o | output | 32 | Byte address of the access |
| mem_be_o | output | 4 | Lane enables |
| mem_wdata_o | output | 32 | Lane-steered store data |
| ld_data_o | output | 32 | Extracted, zero-extended load result |
| wb_en_o | output | 1 | Base register update enable |
| wb_value_o | output | 32 | New base value |
| misalign_o | output | 1 | Access is misaligned |

## Verification
The lane logic is swept over every combination of byte order, size code, low address bits and direction. The store and read words contain four distinct bytes, so a swapped, misrouted or unextended lane gives a different value. Odd halfwords and non-zero word offsets separate the fault path from legal accesses in the same sweep. The three addressing forms are applied with immediate, shifted register and subtracted offsets, which separates the access address from the writeback value. Flipping the byte-order input after reset shows that it is ignored.

// File: rtl/lsu_pkg.sv
package lsu_pkg;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 32;
    localparam int LANES  = DATA_W / 8;
    localparam int LO_W   = $clog2(LANES);

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_WIDE = 2'd3
    } size_e;

    typedef struct packed {
        logic              load;
        size_e             size;
        logic [LO_W-1:0]   lo;
        logic              fault;
        logic              wb;
        logic [ADDR_W-1:0] addr;
        logic [ADDR_W-1:0] wbval;
        logic [DATA_W-1:0] wdata;
        logic [LANES-1:0]  be;
    } acc_t;

    function automatic logic [LO_W-1:0] lane_of(input logic [LO_W-1:0] off, input logic big);
        return big ? LO_W'(LANES - 1) - off : off;
    endfunction

    function automatic logic is_misaligned(input size_e sz, input logic [LO_W-1:0] lo);
        case (sz)
            SZ_BYTE: return 1'b0;
            SZ_HALF: return lo[0];
            default: return |lo;
        endcase
    endfunction
endpackage

// File: rtl/lsu_agen.sv
module lsu_agen
    import lsu_pkg::*;
#(
    parameter int IMM_W   = 12,
    parameter int SHAMT_W = 5
) (
    input  logic [ADDR_W-1:0]  base,
    input  logic [IMM_W-1:0]   imm,
    input  logic [ADDR_W-1:0]  roff,
    input  logic [SHAMT_W-1:0] shamt,
    input  logic               use_reg,
    input  logic               sub,
    input  logic               pre,
    input  logic               wb,
    output logic [ADDR_W-1:0]  addr,
    output logic [ADDR_W-1:0]  wbval,
    output logic               wb_req
);
    logic [ADDR_W-1:0] off;
    logic [ADDR_W-1:0] sum;

    always_comb begin
        off    = use_reg ? (roff << shamt) : ADDR_W'(imm);
        sum    = sub ? (base - off) : (base + off);
        addr   = pre ? sum : base;
        wbval  = sum;
        wb_req = !pre || wb;
    end
endmodule

// File: rtl/lsu_store_steer.sv
module lsu_store_steer
    import lsu_pkg::*;
(
    input  size_e             size,
    input  logic [LO_W-1:0]   lo,
    input  logic              big,
    input  logic [DATA_W-1:0] st_data,
    output logic [LANES-1:0]  be,
    output logic [DATA_W-1:0] wdata,
    output logic              fault
);
    logic [LO_W-1:0] lo_next;

    always_comb begin
        lo_next = {lo[LO_W-1:1], 1'b1};
        fault   = is_misaligned(size, lo);
        be      = '0;
        case (size)
            SZ_BYTE: begin
                be[lane_of(lo, big)] = 1'b1;
                wdata = {LANES{st_data[7:0]}};
            end
            SZ_HALF: begin
                be[lane_of(lo, big)]      = 1'b1;
                be[lane_of(lo_next, big)] = 1'b1;
                wdata = {(LANES/2){st_data[15:0]}};
            end
            default: begin
                be    = '1;
                wdata = st_data;
            end
        endcase
        if (fault) be = '0;
    end
endmodule

// File: rtl/lsu_load_extract.sv
module lsu_load_extract
    import lsu_pkg::*;
(
    input  size_e             size,
    input  logic [LO_W-1:0]   lo,
    input  logic              big,
    input  logic [DATA_W-1:0] rdata,
    output logic [DATA_W-1:0] value
);
    logic [LO_W-1:0] lo_next;
    logic [7:0]      b_lo;
    logic [7:0]      b_hi;

    always_comb begin
        lo_next = {lo[LO_W-1:1], 1'b1};
        b_lo    = rdata[8*lane_of(lo, big) +: 8];
        b_hi    = rdata[8*lane_of(lo_next, big) +: 8];
        case (size)
            SZ_BYTE: value = DATA_W'(b_lo);
            SZ_HALF: value = big ? DATA_W'({b_lo, b_hi}) : DATA_W'({b_hi, b_lo});
            default: value = rdata;
        endcase
    end
endmodule

// File: rtl/lsu_addr_lane.sv
module lsu_addr_lane
    import lsu_pkg::*;
#(
    parameter int IMM_W   = 12,
    parameter int SHAMT_W = 5
) (
    input  logic               clk_i,
    input  logic               rst_i,
    input  logic               cfg_big_endian_i,
    input  logic               req_valid_i,
    input  logic               req_load_i,
    input  logic [1:0]         req_size_i,
    input  logic               req_pre_i,
    input  logic               req_wb_i,
    input  logic               req_sub_i,
    input  logic               req_use_reg_i,
    input  logic [ADDR_W-1:0]  base_i,
    input  logic [IMM_W-1:0]   imm_i,
    input  logic [ADDR_W-1:0]  roff_i,
    input  logic [SHAMT_W-1:0] shamt_i,
    input  logic [DATA_W-1:0]  st_data_i,
    input  logic [DATA_W-1:0]  mem_rdata_i,
    output logic               mem_valid_o,
    output logic               mem_write_o,
    output logic [ADDR_W-1:0]  mem_addr_o,
    output logic [LANES-1:0]   mem_be_o,
    output logic [DATA_W-1:0]  mem_wdata_o,
    output logic [DATA_W-1:0]  ld_data_o,
    output logic               wb_en_o,
    output logic [ADDR_W-1:0]  wb_value_o,
    output logic               misalign_o
);
    logic              endian_q;
    logic              valid_q;
    acc_t              acc_q;
    acc_t              acc_d;
    size_e             size_in;
    logic [ADDR_W-1:0] ea;
    logic [ADDR_W-1:0] ea_wb;
    logic              wb_req;
    logic [LANES-1:0]  be_c;
    logic [DATA_W-1:0] wdata_c;
    logic              fault_c;
    logic [DATA_W-1:0] ld_c;

    assign size_in = size_e'(req_size_i);

    lsu_agen #(.IMM_W(IMM_W), .SHAMT_W(SHAMT_W)) u_agen (
        .base    (base_i),
        .imm     (imm_i),
        .roff    (roff_i),
        .shamt   (shamt_i),
        .use_reg (req_use_reg_i),
        .sub     (req_sub_i),
        .pre     (req_pre_i),
        .wb      (req_wb_i),
        .addr    (ea),
        .wbval   (ea_wb),
        .wb_req  (wb_req)
    );

    lsu_store_steer u_steer (
        .size    (size_in),
        .lo      (ea[LO_W-1:0]),
        .big     (endian_q),
        .st_data (st_data_i),
        .be      (be_c),
        .wdata   (wdata_c),
        .fault   (fault_c)
    );

    always_comb begin
        acc_d       = '0;
        acc_d.load  = req_load_i;
        acc_d.size  = size_in;
        acc_d.lo    = ea[LO_W-1:0];
        acc_d.fault = fault_c;
        acc_d.wb    = wb_req && !fault_c;
        acc_d.addr  = ea;
        acc_d.wbval = ea_wb;
        acc_d.wdata = req_load_i ? '0 : wdata_c;
        acc_d.be    = be_c;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            endian_q <= cfg_big_endian_i;
            valid_q  <= 1'b0;
            acc_q    <= '0;
        end else begin
            valid_q  <= req_valid_i;
            acc_q    <= req_valid_i ? acc_d : '0;
        end
    end

    lsu_load_extract u_extract (
        .size  (acc_q.size),
        .lo    (acc_q.lo),
        .big   (endian_q),
        .rdata (mem_rdata_i),
        .value (ld_c)
    );

    always_comb begin
        mem_valid_o = valid_q;
        mem_write_o = valid_q && !acc_q.load;
        mem_addr_o  = acc_q.addr;
        mem_be_o    = acc_q.be;
        mem_wdata_o = acc_q.wdata;
        ld_data_o   = (valid_q && acc_q.load && !acc_q.fault) ? ld_c : '0;
        wb_en_o     = valid_q && acc_q.wb;
        wb_value_o  = acc_q.wbval;
        misalign_o  = valid_q && acc_q.fault;
    end
endmodule

// File: rtl/lsu_addr_lane_chk.sv
module lsu_addr_lane_chk (
    input logic        clk_i,
    input logic        rst_i,
    input logic        req_valid_i,
    input logic        req_pre_i,
    input logic [31:0] base_i,
    input logic        endian_q,
    input logic        mem_valid_o,
    input logic        mem_write_o,
    input logic [31:0] mem_addr_o,
    input logic [3:0]  mem_be_o,
    input logic [31:0] ld_data_o,
    input logic        wb_en_o,
    input logic        misalign_o
);
    p_fault_quiet_r10: assert property (@(posedge clk_i) disable iff (rst_i)
        misalign_o |-> (mem_be_o == 4'b0 && !wb_en_o && ld_data_o == 32'b0));

    p_lane_count_r7: assert property (@(posedge clk_i) disable iff (rst_i)
        (mem_valid_o && !misalign_o) |->
            ($countones(mem_be_o) == 1 || $countones(mem_be_o) == 2 || mem_be_o == 4'hF));

    p_post_addr_r5: assert property (@(posedge clk_i) disable iff (rst_i)
        (!$past(rst_i) && $past(req_valid_i) && !$past(req_pre_i)) |-> (mem_addr_o == $past(base_i)));

    p_idle_r6: assert property (@(posedge clk_i) disable iff (rst_i)
        (!$past(rst_i) && !$past(req_valid_i)) |-> (!mem_valid_o && !wb_en_o && !mem_write_o));

    p_idle_load_r9: assert property (@(posedge clk_i) disable iff (rst_i)
        (!mem_valid_o || mem_write_o) |-> (ld_data_o == 32'b0));

    p_endian_hold_r11: assert property (@(posedge clk_i) disable iff (rst_i)
        !$past(rst_i) |-> $stable(endian_q));
endmodule

bind lsu_addr_lane lsu_addr_lane_chk u_chk (
    .clk_i       (clk_i),
    .rst_i       (rst_i),
    .req_valid_i (req_valid_i),
    .req_pre_i   (req_pre_i),
    .base_i      (base_i),
    .endian_q    (endian_q),
    .mem_valid_o (mem_valid_o),
    .mem_write_o (mem_write_o),
    .mem_addr_o  (mem_addr_o),
    .mem_be_o    (mem_be_o),
    .ld_data_o   (ld_data_o),
    .wb_en_o     (wb_en_o),
    .misalign_o  (misalign_o)
);

// File: tb/lsu_addr_lane_tb.sv
module lsu_addr_lane_tb;
    logic        clk = 1'b0;
    logic        rst_i;
    logic        cfg_big_endian_i;
    logic        req_valid_i, req_load_i, req_pre_i, req_wb_i, req_sub_i, req_use_reg_i;
    logic [1:0]  req_size_i;
    logic [31:0] base_i, roff_i, st_data_i, mem_rdata_i;
    logic [11:0] imm_i;
    logic [4:0]  shamt_i;
    logic        mem_valid_o, mem_write_o, wb_en_o, misalign_o;
    logic [31:0] mem_addr_o, mem_wdata_o, ld_data_o, wb_value_o;
    logic [3:0]  mem_be_o;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    lsu_addr_lane u_dut (
        .clk_i(clk), .rst_i(rst_i), .cfg_big_endian_i(cfg_big_endian_i),
        .req_valid_i(req_valid_i), .req_load_i(req_load_i), .req_size_i(req_size_i),
        .req_pre_i(req_pre_i), .req_wb_i(req_wb_i), .req_sub_i(req_sub_i),
        .req_use_reg_i(req_use_reg_i), .base_i(base_i), .imm_i(imm_i), .roff_i(roff_i),
        .shamt_i(shamt_i), .st_data_i(st_data_i), .mem_rdata_i(mem_rdata_i),
        .mem_valid_o(mem_valid_o), .mem_write_o(mem_write_o), .mem_addr_o(mem_addr_o),
        .mem_be_o(mem_be_o), .mem_wdata_o(mem_wdata_o), .ld_data_o(ld_data_o),
        .wb_en_o(wb_en_o), .wb_value_o(wb_value_o), .misalign_o(misalign_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic idle_inputs();
        req_valid_i = 0; req_load_i = 0; req_size_i = 0; req_pre_i = 1; req_wb_i = 0;
        req_sub_i = 0; req_use_reg_i = 0; base_i = 0; imm_i = 0; roff_i = 0; shamt_i = 0;
        st_data_i = 0; mem_rdata_i = 0;
    endtask

    task automatic do_reset(input logic big);
        @(negedge clk);
        idle_inputs();
        rst_i = 1; cfg_big_endian_i = big;
        @(negedge clk); @(negedge clk);
        #1;
        chk("R1 valid in reset", 32'(mem_valid_o), 0);
        chk("R1 be in reset", 32'(mem_be_o), 0);
        rst_i = 0;
        @(negedge clk); #1;
        chk("R1 valid after", 32'(mem_valid_o), 0);
        chk("R1 write after", 32'(mem_write_o), 0);
        chk("R1 wdata after", mem_wdata_o, 0);
        chk("R1 ld after", ld_data_o, 0);
        chk("R1 wb after", 32'(wb_en_o), 0);
        chk("R1 fault after", 32'(misalign_o), 0);
    endtask

    // present one request, then leave outputs visible with the given read word
    task automatic issue(input logic [31:0] rd);
        @(negedge clk);
        req_valid_i = 1;
        @(negedge clk);
        req_valid_i = 0;
        mem_rdata_i = rd;
        #1;
    endtask

    function automatic int lane(input int off, input int big);
        return big ? 3 - off : off;
    endfunction

    function automatic logic [7:0] byte_at(input logic [31:0] w, input int off, input int big);
        return 8'((w >> (8 * lane(off, big))) & 32'hFF);
    endfunction

    logic [31:0] e_addr, e_wb, e_be, e_wd, e_ld;
    int          mis;

    initial begin
        #(20 * 200000);
        n_bad++;
        $display("FAIL watchdog: actual running expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        rst_i = 1; cfg_big_endian_i = 0;
        idle_inputs();

        // lane sweep in both byte orders
        for (int big = 0; big < 2; big++) begin
            do_reset(big[0]);
            for (int sz = 0; sz < 4; sz++) begin
                for (int lo = 0; lo < 4; lo++) begin
                    for (int ld = 0; ld < 2; ld++) begin
                        @(negedge clk);
                        req_load_i = ld[0]; req_size_i = sz[1:0]; req_pre_i = 1; req_wb_i = 0;
                        req_use_reg_i = 0; req_sub_i = 0; imm_i = 12'(lo);
                        base_i = 32'h2000_0040; st_data_i = 32'hA1B2_C3D4;
                        issue(32'h1122_3344);
                        mis = ((sz == 1 && (lo % 2) == 1) || (sz >= 2 && lo != 0)) ? 1 : 0;
                        e_be = 0; e_wd = 0; e_ld = 0;
                        if (sz == 0) begin
                            e_be = 32'(1) << lane(lo, big);
                            e_wd = 32'hD4D4_D4D4;
                            e_ld = 32'(byte_at(mem_rdata_i, lo, big));
                        end else if (sz == 1) begin
                            e_be = (32'(1) << lane(lo & 2, big)) | (32'(1) << lane((lo & 2) + 1, big));
                            e_wd = 32'hC3D4_C3D4;
                            if (big != 0)
                                e_ld = (32'(byte_at(mem_rdata_i, lo, big)) << 8) | 32'(byte_at(mem_rdata_i, lo + 1, big));
                            else
                                e_ld = (32'(byte_at(mem_rdata_i, lo + 1, big)) << 8) | 32'(byte_at(mem_rdata_i, lo, big));
                        end else begin
                            e_be = 32'hF;
                            e_wd = 32'hA1B2_C3D4;
                            for (int a = 0; a < 4; a++)
                                e_ld = e_ld | (32'(byte_at(mem_rdata_i, a, big)) << (8 * (big != 0 ? 3 - a : a)));
                        end
                        if (mis != 0) begin e_be = 0; e_ld = 0; end
                        if (ld != 0) e_wd = 0; else e_ld = 0;
                        chk("R6 valid", 32'(mem_valid_o), 1);
                        chk("R6 write", 32'(mem_write_o), 32'(ld == 0));
                        chk("R10 fault", 32'(misalign_o), 32'(mis));
                        chk("R7 lanes", 32'(mem_be_o), e_be);
                        chk("R8 store data", mem_wdata_o, e_wd);
                        chk("R9 load data", ld_data_o, e_ld);
                        chk("R10 no wb", 32'(wb_en_o), 0);
                        chk("R2 addr", mem_addr_o, 32'h2000_0040 + 32'(lo));
                    end
                end
            end
            @(negedge clk); #1;
            chk("R6 idle", 32'(mem_valid_o), 0);
        end

        // addressing forms (little-endian, word-sized, aligned)
        do_reset(1'b0);
        for (int mode = 0; mode < 6; mode++) begin
            logic [31:0] off;
            @(negedge clk);
            req_load_i = 1; req_size_i = 2; base_i = 32'h1000_0100;
            imm_i = 12'h0F0; roff_i = 32'h0000_0041; shamt_i = 2;
            req_use_reg_i = (mode >= 3); req_sub_i = (mode == 4 || mode == 1);
            req_pre_i = (mode != 2 && mode != 5); req_wb_i = (mode == 1 || mode == 4 || mode == 2);
            off = req_use_reg_i ? (32'h41 * 4) : 32'h0F0;
            e_wb = req_sub_i ? 32'h1000_0100 - off : 32'h1000_0100 + off;
            e_addr = req_pre_i ? e_wb : 32'h1000_0100;
            // word alignment of the shifted register offset keeps every case legal
            issue(32'hCAFE_F00D);
            chk("R2 R3 R4 R5 address", mem_addr_o, e_addr);
            chk("R3 R4 R5 wb enable", 32'(wb_en_o), 32'(!req_pre_i || req_wb_i));
            chk("R4 R5 wb value", wb_value_o, e_wb);
            chk("R9 word load", ld_data_o, 32'hCAFE_F00D);
        end
        // subtract wrap
        @(negedge clk);
        req_use_reg_i = 0; req_sub_i = 1; req_pre_i = 1; req_wb_i = 1; base_i = 32'h10; imm_i = 12'h20;
        issue(0);
        chk("R2 wrap", wb_value_o, 32'hFFFF_FFF0);

        // byte order input ignored after reset
        @(negedge clk);
        cfg_big_endian_i = 1;
        req_load_i = 0; req_size_i = 0; req_sub_i = 0; req_pre_i = 1; req_wb_i = 0;
        base_i = 32'h300; imm_i = 0;
        issue(0);
        chk("R11 order held", 32'(mem_be_o), 32'h1);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule